// File: doc/BRIEF.md
# CCD Line Framer with Black-Level Clamp

This block sits behind the three analogue-to-digital converters of a linear colour image sensor. The red, green and blue converters each deliver one sample per pixel period, and all three follow the same slot timing. A strobe marks the first slot of each line. The block numbers the slots of the line and classes each one as a non-image dummy, an optical-black reference or an image pixel. It averages the black reference of each channel and subtracts that average from every image pixel of the same line and channel.

The result is a stream of 5340 corrected pixels per channel for each line. A valid flag qualifies the stream, and first-pixel and last-pixel markers frame it. If the line strobe comes back before the line layout is complete, the block drops the rest of the broken line, raises a one-cycle error pulse and starts the new line. Converter control and the alignment of the colour rows are handled elsewhere.

Top module: `ccd_line_framer`

## Requirements
- R1: After reset, out_valid, out_sol, out_eol and line_err are low. Samples offered without a line strobe before the first line has started produce no output.
- R2: A line is 5415 accepted samples. The sample accepted with line_start high is slot 1. Slots 70 to 5409 are image pixels, and each of them produces exactly one out_valid beat, so a complete line gives 5340 beats.
- R3: out_sol is high only on the beat for slot 70, and out_eol is high only on the beat for slot 5409. Each appears once per complete line and never on the same beat as the other.
- R4: For each channel on its own, the black level is the sum of its samples in slots 18 to 67 divided by 50, rounded to the nearest integer with halves rounded up.
- R5: Each output pixel is the input sample minus the black level of its channel, and the result is 0 when the black level exceeds the sample.
- R6: Slots 1 to 17, 68, 69 and 5410 to 5415 never produce output, and their sample values affect no output. Slots 18 to 67 affect the output only through the black level.
- R7: A line_start accepted while a line is still short of slot 5415 raises line_err for one beat. That sample becomes slot 1 of a new line, and the broken line gives no further beats and no out_eol.
- R8: After slot 5415, samples without line_start are ignored. A line_start that follows a complete line raises no line_err.
- R9: A slot advances only on a cycle with in_valid high. line_start is ignored on a cycle with in_valid low.
- R10: The output beat for an accepted sample appears on the clock edge after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample set is present on the three channel inputs |
| line_start | input | 1 | The current sample set is slot 1 of a line |
| in_r | input | SAMPLE_W | Red sample |
| in_g | input | SAMPLE_W | Green sample |
| in_b | input | SAMPLE_W | Blue sample |
| out_valid | output | 1 | A corrected image pixel is present |
| out_sol | output | 1 | The beat carries the first image pixel of the line |
| out_eol | output | 1 | The beat carries the last image pixel of the line |
| out_r | output | SAMPLE_W | Corrected red pixel |
| out_g | output | SAMPLE_W | Corrected green pixel |
| out_b | output | SAMPLE_W | Corrected blue pixel |
| line_err | output | 1 | One-beat pulse when a line is cut short by a new strobe |

## Verification
A slot counter that is off by one shifts both framing markers and moves the pixel window. The error then shows at the ports on the first image beat of a line, either as a wrong out_sol position or as a pixel value taken from the wrong sample. A wrong black accumulator or a wrong rounding step leaves the framing intact but offsets every pixel of that channel from slot 70 on. The rounding test places a channel exactly on a half step, so a truncating divider fails there. A tracker that stays active after slot 5415, or that misses a cut-short line, shows on the next strobe as a spurious or missing line_err, or as beats outside any line.

// File: rtl/ccd_framer_pkg.sv
package ccd_framer_pkg;

    localparam int NUM_CHANNELS = 3;

    typedef enum logic [1:0] {
        KIND_DUMMY = 2'd0,
        KIND_BLACK = 2'd1,
        KIND_PIXEL = 2'd2
    } slot_kind_e;

    // Classification of the sample set presented in the current cycle.
    typedef struct packed {
        logic       take;        // sample belongs to a line
        logic       restart;     // sample is slot 1
        logic       abort;       // previous line was cut short
        slot_kind_e kind;
        logic       first;       // first image pixel
        logic       last;        // last image pixel
        logic       latch_mean;  // black sum is complete, latch average
    } slot_tag_t;

    // Output-side framing flags.
    typedef struct packed {
        logic valid;
        logic sol;
        logic eol;
        logic err;
    } beat_flags_t;

    // Reciprocal rounded upward, so that exact halves still round up
    // after the fixed-point multiply.
    function automatic int unsigned recip_ceil(input int unsigned count,
                                               input int unsigned shift);
        return ((32'd1 << shift) + count - 32'd1) / count;
    endfunction

endpackage

// File: rtl/ccd_slot_tracker.sv
module ccd_slot_tracker
    import ccd_framer_pkg::*;
#(
    parameter int SLOTS_PER_LINE = 5415,
    parameter int LEAD_DUMMIES   = 69,
    parameter int BLACK_FIRST    = 18,
    parameter int BLACK_LAST     = 67,
    parameter int PIXELS         = 5340
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      line_start,
    output slot_tag_t tag
);
    localparam int SLOT_W = $clog2(SLOTS_PER_LINE + 1);
    localparam logic [SLOT_W-1:0] S_END      = SLOT_W'(SLOTS_PER_LINE);
    localparam logic [SLOT_W-1:0] S_BLK_LO   = SLOT_W'(BLACK_FIRST);
    localparam logic [SLOT_W-1:0] S_BLK_HI   = SLOT_W'(BLACK_LAST);
    localparam logic [SLOT_W-1:0] S_MEAN     = SLOT_W'(BLACK_LAST + 1);
    localparam logic [SLOT_W-1:0] S_PIX_LO   = SLOT_W'(LEAD_DUMMIES + 1);
    localparam logic [SLOT_W-1:0] S_PIX_HI   = SLOT_W'(LEAD_DUMMIES + PIXELS);

    logic [SLOT_W-1:0] slot_q;
    logic              active_q;
    logic [SLOT_W-1:0] idx;

    always_comb begin
        idx = '0;
        tag = '0;
        if (in_valid) begin
            if (line_start) begin
                idx         = SLOT_W'(1);
                tag.take    = 1'b1;
                tag.restart = 1'b1;
                tag.abort   = active_q;
            end else if (active_q) begin
                idx      = slot_q + SLOT_W'(1);
                tag.take = 1'b1;
            end
        end
        if (tag.take) begin
            if (idx >= S_BLK_LO && idx <= S_BLK_HI) begin
                tag.kind = KIND_BLACK;
            end else if (idx >= S_PIX_LO && idx <= S_PIX_HI) begin
                tag.kind = KIND_PIXEL;
            end else begin
                tag.kind = KIND_DUMMY;
            end
            tag.first      = (idx == S_PIX_LO);
            tag.last       = (idx == S_PIX_HI);
            tag.latch_mean = (idx == S_MEAN);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            active_q <= 1'b0;
        end else if (tag.take) begin
            slot_q   <= idx;
            active_q <= (idx != S_END);
        end
    end

endmodule

// File: rtl/ccd_black_channel.sv
module ccd_black_channel #(
    parameter int SAMPLE_W    = 12,
    parameter int BLACK_COUNT = 50,
    parameter int RECIP_SHIFT = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic                restart,
    input  logic                is_black,
    input  logic                latch_mean,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] corrected
);
    localparam int SUM_W  = SAMPLE_W + $clog2(BLACK_COUNT + 1);
    localparam int PROD_W = SUM_W + RECIP_SHIFT + 2;
    localparam int unsigned RECIP = ccd_framer_pkg::recip_ceil(BLACK_COUNT, RECIP_SHIFT);

    logic [SUM_W-1:0]    sum_q;
    logic [SAMPLE_W-1:0] mean_q;
    logic [PROD_W-1:0]   prod;
    logic [SAMPLE_W-1:0] mean_next;

    assign prod      = PROD_W'(sum_q) * PROD_W'(RECIP) + (PROD_W'(1) << (RECIP_SHIFT - 1));
    assign mean_next = SAMPLE_W'(prod >> RECIP_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q  <= '0;
            mean_q <= '0;
        end else if (take) begin
            if (restart) begin
                sum_q <= is_black ? SUM_W'(sample) : '0;
            end else if (is_black) begin
                sum_q <= sum_q + SUM_W'(sample);
            end
            if (latch_mean) begin
                mean_q <= mean_next;
            end
        end
    end

    assign corrected = (sample > mean_q) ? (sample - mean_q) : '0;

endmodule

// File: rtl/ccd_line_framer.sv
module ccd_line_framer
    import ccd_framer_pkg::*;
#(
    parameter int SAMPLE_W       = 12,
    parameter int SLOTS_PER_LINE = 5415,
    parameter int LEAD_DUMMIES   = 69,
    parameter int BLACK_FIRST    = 18,
    parameter int BLACK_LAST     = 67,
    parameter int PIXELS         = 5340,
    parameter int RECIP_SHIFT    = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                line_start,
    input  logic [SAMPLE_W-1:0] in_r,
    input  logic [SAMPLE_W-1:0] in_g,
    input  logic [SAMPLE_W-1:0] in_b,
    output logic                out_valid,
    output logic                out_sol,
    output logic                out_eol,
    output logic [SAMPLE_W-1:0] out_r,
    output logic [SAMPLE_W-1:0] out_g,
    output logic [SAMPLE_W-1:0] out_b,
    output logic                line_err
);
    localparam int BLACK_COUNT = BLACK_LAST - BLACK_FIRST + 1;

    slot_tag_t           tag;
    beat_flags_t         flags_q;
    logic [SAMPLE_W-1:0] chan_in   [NUM_CHANNELS];
    logic [SAMPLE_W-1:0] chan_corr [NUM_CHANNELS];
    logic [SAMPLE_W-1:0] chan_q    [NUM_CHANNELS];
    logic                is_pixel;

    assign chan_in[0] = in_r;
    assign chan_in[1] = in_g;
    assign chan_in[2] = in_b;

    ccd_slot_tracker #(
        .SLOTS_PER_LINE (SLOTS_PER_LINE),
        .LEAD_DUMMIES   (LEAD_DUMMIES),
        .BLACK_FIRST    (BLACK_FIRST),
        .BLACK_LAST     (BLACK_LAST),
        .PIXELS         (PIXELS)
    ) tracker_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .line_start (line_start),
        .tag        (tag)
    );

    assign is_pixel = tag.take && (tag.kind == KIND_PIXEL);

    for (genvar c = 0; c < NUM_CHANNELS; c++) begin : g_chan
        ccd_black_channel #(
            .SAMPLE_W    (SAMPLE_W),
            .BLACK_COUNT (BLACK_COUNT),
            .RECIP_SHIFT (RECIP_SHIFT)
        ) black_i (
            .clk        (clk),
            .rst        (rst),
            .take       (tag.take),
            .restart    (tag.restart),
            .is_black   (tag.kind == KIND_BLACK),
            .latch_mean (tag.latch_mean),
            .sample     (chan_in[c]),
            .corrected  (chan_corr[c])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                chan_q[c] <= '0;
            end else begin
                chan_q[c] <= is_pixel ? chan_corr[c] : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.valid <= is_pixel;
            flags_q.sol   <= is_pixel && tag.first;
            flags_q.eol   <= is_pixel && tag.last;
            flags_q.err   <= tag.abort;
        end
    end

    assign out_valid = flags_q.valid;
    assign out_sol   = flags_q.sol;
    assign out_eol   = flags_q.eol;
    assign line_err  = flags_q.err;
    assign out_r     = chan_q[0];
    assign out_g     = chan_q[1];
    assign out_b     = chan_q[2];

endmodule

// File: rtl/ccd_line_framer_chk.sv
module ccd_line_framer_chk #(
    parameter int SAMPLE_W = 12,
    parameter int PIXELS   = 5340
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                line_start,
    input logic [SAMPLE_W-1:0] in_r,
    input logic [SAMPLE_W-1:0] in_g,
    input logic [SAMPLE_W-1:0] in_b,
    input logic                out_valid,
    input logic                out_sol,
    input logic                out_eol,
    input logic [SAMPLE_W-1:0] out_r,
    input logic [SAMPLE_W-1:0] out_g,
    input logic [SAMPLE_W-1:0] out_b,
    input logic                line_err
);
    localparam int CNT_W = $clog2(PIXELS + 1);

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (out_sol) begin
            run_q <= CNT_W'(1);
        end else if (out_valid) begin
            run_q <= run_q + CNT_W'(1);
        end
    end

    p_markers_qualified_r3: assert property (@(posedge clk) disable iff (rst)
        (out_sol || out_eol) |-> out_valid);

    p_markers_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(out_sol && out_eol));

    p_eol_after_full_run_r2: assert property (@(posedge clk) disable iff (rst)
        out_eol |-> (run_q == CNT_W'(PIXELS - 1)));

    p_beat_follows_sample_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    p_slot_one_silent_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$past(in_valid && line_start));

    p_err_from_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        line_err |-> $past(in_valid && line_start));

    p_clamp_not_above_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_r <= $past(in_r) && out_g <= $past(in_g) && out_b <= $past(in_b)));

endmodule

bind ccd_line_framer ccd_line_framer_chk #(
    .SAMPLE_W (SAMPLE_W),
    .PIXELS   (PIXELS)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .line_start (line_start),
    .in_r       (in_r),
    .in_g       (in_g),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_sol    (out_sol),
    .out_eol    (out_eol),
    .out_r      (out_r),
    .out_g      (out_g),
    .out_b      (out_b),
    .line_err   (line_err)
);

// File: tb/ccd_line_framer_tb.sv
module ccd_line_framer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SW         = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          line_start = 1'b0;
    logic [SW-1:0] in_r = '0, in_g = '0, in_b = '0;
    logic          out_valid, out_sol, out_eol, line_err;
    logic [SW-1:0] out_r, out_g, out_b;

    int tests_run = 0;
    int tests_failed = 0;

    // reference model state
    bit b_active = 0;
    int b_slot = 0;
    int b_sum[3];
    int b_mean[3];
    bit exp_valid = 0, exp_sol = 0, exp_eol = 0, exp_err = 0;
    int exp_d[3];

    // per-window observations
    int n_valid, n_sol, n_eol, n_err, n_zero, cyc_bad;
    string first_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccd_line_framer dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .line_start(line_start),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_sol(out_sol), .out_eol(out_eol),
        .out_r(out_r), .out_g(out_g), .out_b(out_b), .line_err(line_err)
    );

    function automatic int pix(int pat, int ch, int idx);
        if (idx >= 18 && idx <= 67) begin
            case (pat)
                0: return 200 + ch*10 + (idx % 7);
                1: return (idx == 40) ? 125 + ch : 100 + ch;
                default: return 0;
            endcase
        end else if (idx >= 70 && idx <= 5409) begin
            case (pat)
                0: return (idx*3 + ch*500) % 4096;
                1: return 95 + ch + (idx % 10);
                default: return 4095 - (idx % 1000) - ch;
            endcase
        end
        return (pat == 2) ? 0 : 4095;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic clear_window();
        n_valid = 0; n_sol = 0; n_eol = 0; n_err = 0; n_zero = 0; cyc_bad = 0;
        first_bad = "";
    endtask

    task automatic compare();
        bit bad;
        bad = (out_valid !== exp_valid) || (out_sol !== exp_sol) ||
              (out_eol !== exp_eol) || (line_err !== exp_err);
        if (exp_valid && (out_r !== SW'(exp_d[0]) || out_g !== SW'(exp_d[1]) ||
                          out_b !== SW'(exp_d[2])))
            bad = 1;
        if (bad) begin
            cyc_bad++;
            if (cyc_bad == 1)
                first_bad = $sformatf("v%0b s%0b e%0b x%0b %0d/%0d/%0d vs v%0b s%0b e%0b x%0b %0d/%0d/%0d",
                    out_valid, out_sol, out_eol, line_err, out_r, out_g, out_b,
                    exp_valid, exp_sol, exp_eol, exp_err, exp_d[0], exp_d[1], exp_d[2]);
        end
        if (out_valid === 1'b1) begin
            n_valid++;
            if (out_r == 0) n_zero++;
        end
        if (out_sol === 1'b1) n_sol++;
        if (out_eol === 1'b1) n_eol++;
        if (line_err === 1'b1) n_err++;
    endtask

    task automatic drive_sample(bit v, bit ls, int pat);
        bit acc;
        @(negedge clk);
        compare();
        in_valid = v; line_start = ls;
        exp_valid = 0; exp_sol = 0; exp_eol = 0; exp_err = 0;
        exp_d[0] = 0; exp_d[1] = 0; exp_d[2] = 0;
        acc = 0;
        if (v) begin
            if (ls) begin
                exp_err = b_active; b_active = 1; b_slot = 1; acc = 1;
                for (int c = 0; c < 3; c++) b_sum[c] = 0;
            end else if (b_active) begin
                b_slot++; acc = 1;
            end
        end
        if (acc) begin
            int val[3];
            for (int c = 0; c < 3; c++) begin
                val[c] = pix(pat, c, b_slot);
                if (b_slot >= 18 && b_slot <= 67) b_sum[c] += val[c];
                if (b_slot == 68) b_mean[c] = (b_sum[c] + 25) / 50;
                if (b_slot >= 70 && b_slot <= 5409)
                    exp_d[c] = (val[c] > b_mean[c]) ? val[c] - b_mean[c] : 0;
            end
            in_r = SW'(val[0]); in_g = SW'(val[1]); in_b = SW'(val[2]);
            exp_valid = (b_slot >= 70 && b_slot <= 5409);
            exp_sol = (b_slot == 70);
            exp_eol = (b_slot == 5409);
            if (b_slot == 5415) b_active = 0;
        end else begin
            in_r = 12'hABC; in_g = 12'h123; in_b = 12'hFFF;
        end
    endtask

    // Plays nslots accepted samples, the first with the line strobe.
    // With gaps, every third slot is preceded by an idle cycle that carries line_start.
    task automatic play(int nslots, int pat, bit gaps);
        for (int k = 1; k <= nslots; k++) begin
            if (gaps && (k % 3 == 0)) drive_sample(0, 1, pat);
            drive_sample(1, k == 1, pat);
        end
        drive_sample(0, 0, pat);
    endtask

    task automatic report_cycles(string req);
        check(cyc_bad == 0, req, "cycle-level mismatches", cyc_bad, 0);
        if (cyc_bad != 0) $display("  first mismatch act|exp: %s", first_bad);
    endtask

    task automatic t_reset();
        clear_window();
        @(negedge clk);
        check(out_valid == 0 && out_sol == 0 && out_eol == 0 && line_err == 0,
              "R1", "outputs after reset", int'({out_valid, out_sol, out_eol, line_err}), 0);
        clear_window();
        for (int k = 0; k < 20; k++) drive_sample(1, 0, 0);
        drive_sample(0, 0, 0);
        check(n_valid == 0, "R1", "beats before first strobe", n_valid, 0);
        report_cycles("R1");
    endtask

    task automatic t_plain_line();
        clear_window();
        play(5415, 0, 0);
        check(n_valid == 5340, "R2", "beats in complete line", n_valid, 5340);
        check(n_sol == 1, "R3", "start markers", n_sol, 1);
        check(n_eol == 1, "R3", "end markers", n_eol, 1);
        check(n_err == 0, "R8", "error on first line", n_err, 0);
        report_cycles("R4 R6 R10");
    endtask

    task automatic t_round_clamp();
        clear_window();
        play(5415, 1, 0);
        report_cycles("R4 R5");
        check(n_zero > 0, "R5", "clamped red pixels seen", n_zero, 1);
        check(n_valid == 5340, "R2", "beats in rounding line", n_valid, 5340);
    endtask

    task automatic t_gaps();
        clear_window();
        play(5415, 2, 1);
        check(n_valid == 5340, "R9", "beats with idle gaps", n_valid, 5340);
        check(n_err == 0, "R9", "errors from idle strobes", n_err, 0);
        report_cycles("R9");
    endtask

    task automatic t_abort();
        clear_window();
        play(3000, 0, 0);
        check(n_valid == 2931, "R7", "beats before cut", n_valid, 2931);
        check(n_eol == 0, "R7", "end marker on cut line", n_eol, 0);
        clear_window();
        play(5415, 1, 0);
        check(n_err == 1, "R7", "error pulses on restart", n_err, 1);
        check(n_valid == 5340, "R7", "beats in line after cut", n_valid, 5340);
        report_cycles("R7");
    endtask

    task automatic t_tail();
        clear_window();
        for (int k = 0; k < 30; k++) drive_sample(1, 0, 0);
        drive_sample(0, 0, 0);
        check(n_valid == 0, "R8", "beats after slot 5415", n_valid, 0);
        clear_window();
        play(5415, 0, 0);
        check(n_err == 0, "R8", "error after complete line", n_err, 0);
        check(n_eol == 1, "R8", "end marker of next line", n_eol, 1);
        report_cycles("R8");
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        tests_run++;
        tests_failed++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        for (int c = 0; c < 3; c++) begin b_sum[c] = 0; b_mean[c] = 0; exp_d[c] = 0; end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain_line();
        t_round_clamp();
        t_gaps();
        t_abort();
        t_tail();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule